// File: doc/BRIEF.md
# Column Command Latency Scheduler

This block sits between the command issue stage of a DDR3-class memory controller and its data-path sequencer. Each registered read or write column command enters the block together with its bank number and two address bits. The block then produces the data-phase enables that the data path needs. A read window opens a fixed number of clocks after the command. That number is the read latency, equal to the additive latency plus the CAS latency. A write window opens after the write latency, equal to the additive latency plus the CAS write latency.

The settings come in through a load strobe: CAS latency, a selector for additive latency (zero, CL minus one or CL minus two), CAS write latency and burst mode. A load that would give an illegal combination is refused. The block keeps the previous settings and raises an error flag. Every command travels down a delay line, so several commands can be in flight at once. Each window is four controller clocks long. A full burst drives data valid for all four clocks. A chopped burst drives data valid for only the first two, but still occupies the whole slot. When a command asks for auto-precharge, a one-cycle request carrying the bank number goes to the bank tracker on the last clock of that command's window.

Top module: `col_latency_sched`

## Requirements
- R1: CAS latency loads accept any value from 5 to 11. `readLat` shows the read latency one clock after the load edge.
- R2: The additive-latency selector `cfgAddSel` decodes as 0 → AL = 0, 1 → AL = CL−1, 2 → AL = CL−2. `readLat` = AL+CL and `writeLat` = AL+CWL.
- R3: A read captured on rising edge t0 holds `rdSlot` high in the four cycles that follow edges t0+RL through t0+RL+3.
- R4: A write captured on edge t0 holds `wrSlot` high in the four cycles that follow edges t0+WL through t0+WL+3. CWL is programmed independently of CL, over the range 5 to 8.
- R5: Burst mode `cfgBurst` decodes as 0 → fixed full burst, 1 → fixed chopped burst, 2 → per-command selection. In a full burst the data enable (`rdEn`/`wrEn`) is high for the whole four-cycle slot. In a chopped burst it is high only in the first two cycles of the slot, and it is never high outside the slot.
- R6: In per-command mode, `cmdBurstBit` (column address bit 12) = 1 selects a full burst and 0 selects a chopped burst. In the fixed modes this bit has no effect.
- R7: A command whose `cmdPrechargeBit` (column address bit 10) is 1 produces a single-cycle `apValid` in the last cycle of its slot, with `apBank` equal to the command's bank. A command with the bit at 0 produces no `apValid`.
- R8: A load is refused when CL lies outside 5..11, CWL lies outside 5..8, `cfgAddSel` = 3 or `cfgBurst` = 3. A refused load leaves the latencies and burst mode unchanged and sets `cfgErr`. The next accepted load clears `cfgErr`.
- R9: A command is captured only on a rising edge where `cmdValid` is high. Commands spaced four or more clocks apart each produce their own complete window, in issue order, with none lost.
- R10: After reset the settings are CL = 5, AL = 0, CWL = 5 and fixed full burst. `cfgErr` is low and no slot, enable or precharge output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all capture on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Load strobe for the four settings below |
| cfgCasLat | input | 4 | CAS latency in clocks |
| cfgAddSel | input | 2 | Additive-latency selector |
| cfgWrLat | input | 4 | CAS write latency in clocks |
| cfgBurst | input | 2 | Burst mode selector |
| cmdValid | input | 1 | A column command is present this cycle |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdBank | input | 3 | Bank number of the command |
| cmdPrechargeBit | input | 1 | Column address bit 10: auto-precharge request |
| cmdBurstBit | input | 1 | Column address bit 12: per-command burst selection |
| rdSlot | output | 1 | Read data slot occupied |
| rdEn | output | 1 | Read data beats valid |
| wrSlot | output | 1 | Write data slot occupied |
| wrEn | output | 1 | Write data beats valid |
| apValid | output | 1 | Auto-precharge request to the bank tracker |
| apBank | output | 3 | Bank for the auto-precharge request |
| cfgErr | output | 1 | Last load was refused |
| readLat | output | 5 | Read latency currently in effect |
| writeLat | output | 5 | Write latency currently in effect |

## Verification
The bound checker watches four things on every cycle. Data enables never fire outside their slot. A precharge request only appears inside a slot. The latencies and error flag move only on a load. A refused CAS latency leaves both latencies untouched. Only the bench's scenarios can show the exact cycle each window opens for every CL and AL pair and for several write latencies. The bench scenarios also cover the two-beat cut of a chopped burst, whether the per-command bit is obeyed or ignored, and the precharge bank number. They also check that back-to-back commands each keep their own window.

// File: rtl/colsched_pkg.sv
package colsched_pkg;
  localparam int BankW = 3;

  typedef enum logic [1:0] {
    AL_ZERO  = 2'd0,
    AL_CL_M1 = 2'd1,
    AL_CL_M2 = 2'd2,
    AL_BAD   = 2'd3
  } alSel_e;

  typedef enum logic [1:0] {
    BM_FIX8 = 2'd0,
    BM_FIX4 = 2'd1,
    BM_OTF  = 2'd2,
    BM_BAD  = 2'd3
  } burstMode_e;

  // One column command as it travels down the delay line
  typedef struct packed {
    logic             valid;
    logic             isWrite;
    logic             chop;
    logic             autoPre;
    logic [BankW-1:0] bank;
  } colEntry_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic      push;
    colEntry_t entry;
  } ctrlStrobe_t;
endpackage

// File: rtl/colsched_ctrl.sv
module colsched_ctrl
  import colsched_pkg::*;
#(
  parameter int CL_MIN  = 5,
  parameter int CL_MAX  = 11,
  parameter int CWL_MIN = 5,
  parameter int CWL_MAX = 8,
  parameter int LAT_W   = 5,
  parameter int CAS_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [CAS_W-1:0] cfgCasLat,
  input  logic [1:0]       cfgAddSel,
  input  logic [CAS_W-1:0] cfgWrLat,
  input  logic [1:0]       cfgBurst,
  input  logic             cmdValid,
  input  logic             cmdWrite,
  input  logic [BankW-1:0] cmdBank,
  input  logic             cmdPrechargeBit,
  input  logic             cmdBurstBit,
  output ctrlStrobe_t      strobe,
  output logic [LAT_W-1:0] readLat,
  output logic [LAT_W-1:0] writeLat,
  output logic             cfgErr
);
  localparam logic [CAS_W-1:0] ClLo  = CAS_W'(CL_MIN);
  localparam logic [CAS_W-1:0] ClHi  = CAS_W'(CL_MAX);
  localparam logic [CAS_W-1:0] CwlLo = CAS_W'(CWL_MIN);
  localparam logic [CAS_W-1:0] CwlHi = CAS_W'(CWL_MAX);

  logic [CAS_W-1:0] clQ, cwlQ;
  alSel_e           alQ;
  burstMode_e       bmQ;
  logic             errQ;
  logic             cfgOk;
  logic [LAT_W-1:0] clExt, alVal;
  logic             chopSel;

  // Legality of a requested setting set
  always_comb begin
    cfgOk = 1'b1;
    if (cfgCasLat < ClLo || cfgCasLat > ClHi) cfgOk = 1'b0;
    if (cfgWrLat < CwlLo || cfgWrLat > CwlHi) cfgOk = 1'b0;
    if (alSel_e'(cfgAddSel) == AL_BAD)        cfgOk = 1'b0;
    if (burstMode_e'(cfgBurst) == BM_BAD)     cfgOk = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clQ  <= ClLo;
      cwlQ <= CwlLo;
      alQ  <= AL_ZERO;
      bmQ  <= BM_FIX8;
      errQ <= 1'b0;
    end else if (cfgLoad) begin
      if (cfgOk) begin
        clQ  <= cfgCasLat;
        cwlQ <= cfgWrLat;
        alQ  <= alSel_e'(cfgAddSel);
        bmQ  <= burstMode_e'(cfgBurst);
        errQ <= 1'b0;
      end else begin
        errQ <= 1'b1;
      end
    end
  end

  // Posted-CAS latency sums
  always_comb begin
    clExt = LAT_W'(clQ);
    unique case (alQ)
      AL_CL_M1: alVal = clExt - LAT_W'(1);
      AL_CL_M2: alVal = clExt - LAT_W'(2);
      default:  alVal = '0;
    endcase
  end

  assign readLat  = alVal + clExt;
  assign writeLat = alVal + LAT_W'(cwlQ);
  assign cfgErr   = errQ;

  // Burst selection per command
  always_comb begin
    unique case (bmQ)
      BM_FIX4: chopSel = 1'b1;
      BM_OTF:  chopSel = ~cmdBurstBit;
      default: chopSel = 1'b0;
    endcase
  end

  always_comb begin
    strobe.push          = cmdValid;
    strobe.entry.valid   = cmdValid;
    strobe.entry.isWrite = cmdWrite;
    strobe.entry.chop    = chopSel;
    strobe.entry.autoPre = cmdPrechargeBit;
    strobe.entry.bank    = cmdBank;
  end
endmodule

// File: rtl/colsched_pipe.sv
module colsched_pipe
  import colsched_pkg::*;
#(
  parameter int DEPTH    = 25,
  parameter int SLOT     = 4,
  parameter int BC_BEATS = 2,
  parameter int LAT_W    = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [LAT_W-1:0] readLat,
  input  logic [LAT_W-1:0] writeLat,
  output logic             rdSlot,
  output logic             rdEn,
  output logic             wrSlot,
  output logic             wrEn,
  output logic             apValid,
  output logic [BankW-1:0] apBank
);
  localparam logic [LAT_W-1:0] LastOff = LAT_W'(SLOT - 1);
  localparam logic [LAT_W-1:0] BcCut   = LAT_W'(BC_BEATS);

  colEntry_t        pipe [DEPTH];
  logic [DEPTH-1:0] rdHit, rdVal, rdAp, wrHit, wrVal, wrAp;
  logic [BankW-1:0] apBankC;

  // Delay line: stage i holds the command captured i edges ago
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= strobe.push ? strobe.entry : '0;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  // Per-stage window decode
  for (genvar g = 0; g < DEPTH; g++) begin : gStage
    localparam logic [LAT_W-1:0] StageIdx = LAT_W'(g);
    logic [LAT_W-1:0] rdOff, wrOff;
    logic             isRd, isWr;
    assign isRd  = pipe[g].valid && !pipe[g].isWrite;
    assign isWr  = pipe[g].valid &&  pipe[g].isWrite;
    assign rdOff = StageIdx - readLat;
    assign wrOff = StageIdx - writeLat;
    assign rdHit[g] = isRd && (StageIdx >= readLat) && (rdOff <= LastOff);
    assign wrHit[g] = isWr && (StageIdx >= writeLat) && (wrOff <= LastOff);
    assign rdVal[g] = rdHit[g] && (!pipe[g].chop || rdOff < BcCut);
    assign wrVal[g] = wrHit[g] && (!pipe[g].chop || wrOff < BcCut);
    assign rdAp[g]  = rdHit[g] && pipe[g].autoPre && (rdOff == LastOff);
    assign wrAp[g]  = wrHit[g] && pipe[g].autoPre && (wrOff == LastOff);
  end

  // Bank for the precharge request, reads take precedence
  always_comb begin
    apBankC = '0;
    for (int i = 0; i < DEPTH; i++) if (wrAp[i]) apBankC = pipe[i].bank;
    for (int i = 0; i < DEPTH; i++) if (rdAp[i]) apBankC = pipe[i].bank;
  end

  assign rdSlot  = |rdHit;
  assign rdEn    = |rdVal;
  assign wrSlot  = |wrHit;
  assign wrEn    = |wrVal;
  assign apValid = |rdAp || |wrAp;
  assign apBank  = apBankC;
endmodule

// File: rtl/col_latency_sched.sv
module col_latency_sched
  import colsched_pkg::*;
#(
  parameter int CL_MIN   = 5,
  parameter int CL_MAX   = 11,
  parameter int CWL_MIN  = 5,
  parameter int CWL_MAX  = 8,
  parameter int SLOT     = 4,
  parameter int BC_BEATS = 2,
  localparam int AlMax   = CL_MAX - 1,
  localparam int RlMax   = AlMax + CL_MAX,
  localparam int WlMax   = AlMax + CWL_MAX,
  localparam int LatMax  = (RlMax > WlMax) ? RlMax : WlMax,
  localparam int Depth   = LatMax + SLOT,
  localparam int LatW    = $clog2(Depth + 1),
  localparam int CasW    = $clog2(CL_MAX + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgLoad,
  input  logic [CasW-1:0] cfgCasLat,
  input  logic [1:0]      cfgAddSel,
  input  logic [CasW-1:0] cfgWrLat,
  input  logic [1:0]      cfgBurst,
  input  logic            cmdValid,
  input  logic            cmdWrite,
  input  logic [2:0]      cmdBank,
  input  logic            cmdPrechargeBit,
  input  logic            cmdBurstBit,
  output logic            rdSlot,
  output logic            rdEn,
  output logic            wrSlot,
  output logic            wrEn,
  output logic            apValid,
  output logic [2:0]      apBank,
  output logic            cfgErr,
  output logic [LatW-1:0] readLat,
  output logic [LatW-1:0] writeLat
);
  ctrlStrobe_t strobe;

  colsched_ctrl #(
    .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .CWL_MIN(CWL_MIN), .CWL_MAX(CWL_MAX),
    .LAT_W(LatW), .CAS_W(CasW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgCasLat(cfgCasLat),
    .cfgAddSel(cfgAddSel), .cfgWrLat(cfgWrLat), .cfgBurst(cfgBurst),
    .cmdValid(cmdValid), .cmdWrite(cmdWrite), .cmdBank(cmdBank),
    .cmdPrechargeBit(cmdPrechargeBit), .cmdBurstBit(cmdBurstBit),
    .strobe(strobe), .readLat(readLat), .writeLat(writeLat), .cfgErr(cfgErr)
  );

  colsched_pipe #(
    .DEPTH(Depth), .SLOT(SLOT), .BC_BEATS(BC_BEATS), .LAT_W(LatW)
  ) u_pipe (
    .clk(clk), .rstN(rstN), .strobe(strobe), .readLat(readLat),
    .writeLat(writeLat), .rdSlot(rdSlot), .rdEn(rdEn), .wrSlot(wrSlot),
    .wrEn(wrEn), .apValid(apValid), .apBank(apBank)
  );
endmodule

// File: rtl/col_latency_sched_chk.sv
module col_latency_sched_chk #(
  parameter int CL_MIN = 5,
  parameter int CL_MAX = 11,
  parameter int LAT_W  = 5,
  parameter int CAS_W  = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgLoad,
  input logic [CAS_W-1:0] cfgCasLat,
  input logic             rdSlot,
  input logic             rdEn,
  input logic             wrSlot,
  input logic             wrEn,
  input logic             apValid,
  input logic             cfgErr,
  input logic [LAT_W-1:0] readLat,
  input logic [LAT_W-1:0] writeLat
);
  localparam logic [CAS_W-1:0] ClLo = CAS_W'(CL_MIN);
  localparam logic [CAS_W-1:0] ClHi = CAS_W'(CL_MAX);

  assert_rd_en_in_slot_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> rdSlot);

  assert_wr_en_in_slot_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrSlot);

  assert_ap_inside_slot_R7: assert property (@(posedge clk) disable iff (!rstN)
    apValid |-> (rdSlot || wrSlot));

  assert_bad_cl_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad && (cfgCasLat < ClLo || cfgCasLat > ClHi)) |=>
      (cfgErr && readLat == $past(readLat) && writeLat == $past(writeLat)));

  assert_cfg_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> ($stable(readLat) && $stable(writeLat) && $stable(cfgErr)));
endmodule

bind col_latency_sched col_latency_sched_chk #(
  .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .LAT_W(LatW), .CAS_W(CasW)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgCasLat(cfgCasLat),
  .rdSlot(rdSlot), .rdEn(rdEn), .wrSlot(wrSlot), .wrEn(wrEn),
  .apValid(apValid), .cfgErr(cfgErr), .readLat(readLat), .writeLat(writeLat)
);

// File: tb/col_latency_sched_tb.sv
`timescale 1ns/1ps
module col_latency_sched_tb;
  localparam int ClkNs = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgLoad = 1'b0;
  logic [3:0] cfgCasLat = 4'd5;
  logic [1:0] cfgAddSel = 2'd0;
  logic [3:0] cfgWrLat = 4'd5;
  logic [1:0] cfgBurst = 2'd0;
  logic       cmdValid = 1'b0;
  logic       cmdWrite = 1'b0;
  logic [2:0] cmdBank = 3'd0;
  logic       cmdPrechargeBit = 1'b0;
  logic       cmdBurstBit = 1'b0;
  logic       rdSlot, rdEn, wrSlot, wrEn, apValid, cfgErr;
  logic [2:0] apBank;
  logic [4:0] readLat, writeLat;

  always #(ClkNs/2) clk = ~clk;

  col_latency_sched u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgCasLat(cfgCasLat),
    .cfgAddSel(cfgAddSel), .cfgWrLat(cfgWrLat), .cfgBurst(cfgBurst),
    .cmdValid(cmdValid), .cmdWrite(cmdWrite), .cmdBank(cmdBank),
    .cmdPrechargeBit(cmdPrechargeBit), .cmdBurstBit(cmdBurstBit),
    .rdSlot(rdSlot), .rdEn(rdEn), .wrSlot(wrSlot), .wrEn(wrEn),
    .apValid(apValid), .apBank(apBank), .cfgErr(cfgErr),
    .readLat(readLat), .writeLat(writeLat)
  );

  int    total = 0;
  int    bad = 0;
  int    cycCount = 0;
  bit    monOn = 1'b0;
  bit    finished = 1'b0;
  string curTag = "R10";

  // Reference settings model
  int mCl = 5, mAl = 0, mCwl = 5, mBm = 0;

  // Issued command list
  int nCmd = 0;
  int cCap [32];
  int cLat [32];
  int cBank [32];
  bit cWr [32];
  bit cChop [32];
  bit cAp [32];

  always @(posedge clk) cycCount++;

  task automatic checkEq(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int alOf(int cl, int sel);
    if (sel == 1) return cl - 1;
    if (sel == 2) return cl - 2;
    return 0;
  endfunction

  // Per-cycle window monitor
  always @(negedge clk) begin
    if (monOn) begin
      bit eRd, eRdS, eWr, eWrS, eAp;
      int eBank;
      int n;
      eRd = 0; eRdS = 0; eWr = 0; eWrS = 0; eAp = 0; eBank = 0;
      for (int k = 0; k < nCmd; k++) begin
        n = cycCount - cCap[k];
        if (n >= cLat[k] && n <= cLat[k] + 3) begin
          if (cWr[k]) begin
            eWrS = 1;
            if (!cChop[k] || n < cLat[k] + 2) eWr = 1;
          end else begin
            eRdS = 1;
            if (!cChop[k] || n < cLat[k] + 2) eRd = 1;
          end
          if (cAp[k] && n == cLat[k] + 3 && (!eAp || !cWr[k])) begin
            eAp = 1;
            eBank = cBank[k];
          end
        end
      end
      total++;
      if ({rdSlot, rdEn, wrSlot, wrEn, apValid} != {eRdS, eRd, eWrS, eWr, eAp} ||
          (eAp && int'(apBank) != eBank)) begin
        bad++;
        $display("FAIL %s cyc=%0d act rdS/rd/wrS/wr/ap=%b%b%b%b%b bank=%0d exp=%b%b%b%b%b bank=%0d",
                 curTag, cycCount, rdSlot, rdEn, wrSlot, wrEn, apValid, apBank,
                 eRdS, eRd, eWrS, eWr, eAp, eBank);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Load settings; caller sits at a negedge
  task automatic loadCfg(int cl, int al, int cwl, int bm, string tag);
    bit ok;
    ok = cl >= 5 && cl <= 11 && cwl >= 5 && cwl <= 8 && al <= 2 && bm <= 2;
    cfgCasLat = 4'(cl); cfgAddSel = 2'(al); cfgWrLat = 4'(cwl); cfgBurst = 2'(bm);
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    if (ok) begin mCl = cl; mAl = alOf(cl, al); mCwl = cwl; mBm = bm; end
    checkEq(tag, "readLat", int'(readLat), mAl + mCl);
    checkEq(tag, "writeLat", int'(writeLat), mAl + mCwl);
    checkEq(tag, "cfgErr", int'(cfgErr), ok ? 0 : 1);
  endtask

  // Issue one command at the current negedge, capture on the next edge
  task automatic issue(bit wr, bit pre, bit bsel, int bank);
    cmdValid = 1'b1; cmdWrite = wr; cmdPrechargeBit = pre;
    cmdBurstBit = bsel; cmdBank = 3'(bank);
    cCap[nCmd]  = cycCount + 1;
    cWr[nCmd]   = wr;
    cAp[nCmd]   = pre;
    cBank[nCmd] = bank;
    cChop[nCmd] = (mBm == 1) || (mBm == 2 && !bsel);
    cLat[nCmd]  = wr ? mAl + mCwl : mAl + mCl;
    nCmd++;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic drain();
    tick(40);
    nCmd = 0;
  endtask

  initial begin
    // R10: reset state
    tick(3);
    checkEq("R10", "readLat", int'(readLat), 5);
    checkEq("R10", "writeLat", int'(writeLat), 5);
    checkEq("R10", "cfgErr", int'(cfgErr), 0);
    checkEq("R10", "outputs", int'({rdSlot, rdEn, wrSlot, wrEn, apValid}), 0);
    rstN = 1'b1;
    tick(2);
    monOn = 1'b1;

    // R10/R6: defaults give a full burst even with burst bit low
    curTag = "R10_R6";
    issue(0, 1, 0, 6);
    tick(3);
    issue(1, 0, 0, 2);
    drain();

    // R1/R2/R3/R4: sweep every CL with every AL choice
    for (int cl = 5; cl <= 11; cl++) begin
      for (int al = 0; al <= 2; al++) begin
        curTag = "R1_R2_R3_R4";
        loadCfg(cl, al, 5 + ((cl + al) % 4), 0, curTag);
        issue(0, 1'((cl + al) % 2), 1, (cl * 3 + al) % 8);
        tick(3);
        issue(1, 1'((cl + al + 1) % 2), 1, (cl + 5 * al) % 8);
        drain();
      end
    end

    // R5: fixed chopped bursts, burst bit ignored
    curTag = "R5_R6";
    loadCfg(7, 1, 6, 1, curTag);
    issue(0, 1, 1, 3);
    tick(3);
    issue(0, 0, 1, 4);
    tick(3);
    issue(1, 1, 0, 5);
    drain();

    // R6: per-command burst selection
    curTag = "R6";
    loadCfg(9, 2, 7, 2, curTag);
    issue(0, 1, 1, 1);
    tick(3);
    issue(0, 1, 0, 2);
    tick(3);
    issue(0, 0, 1, 3);
    tick(7);
    issue(1, 1, 0, 4);
    tick(3);
    issue(1, 1, 1, 7);
    drain();

    // R9/R7: back-to-back reads, then idle bus noise without cmdValid
    curTag = "R9_R7";
    loadCfg(11, 1, 8, 0, curTag);
    for (int i = 0; i < 4; i++) begin
      issue(0, 1, 1, i + 4);
      tick(3);
    end
    for (int i = 0; i < 12; i++) begin
      cmdWrite = 1'(i); cmdBank = 3'(7 - (i % 8));
      cmdPrechargeBit = 1'b1; cmdBurstBit = 1'(i >> 1);
      @(negedge clk);
    end
    drain();

    // R8: refused loads keep settings, good load clears the flag
    curTag = "R8";
    loadCfg(6, 2, 7, 1, curTag);
    loadCfg(4, 0, 5, 0, curTag);
    loadCfg(12, 0, 5, 0, curTag);
    loadCfg(7, 0, 9, 0, curTag);
    loadCfg(7, 0, 4, 0, curTag);
    loadCfg(7, 3, 6, 0, curTag);
    loadCfg(7, 0, 6, 3, curTag);
    issue(0, 1, 1, 5);
    tick(3);
    issue(1, 1, 1, 6);
    drain();
    loadCfg(8, 0, 6, 0, curTag);
    issue(0, 0, 0, 1);
    drain();

    monOn = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    #(ClkNs * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end
endmodule